// File: doc/BRIEF.md
# Dual Prescaled Down-Counter Timer

This peripheral contains two identical down-counting timers. Software reaches them through a word-addressed register port made of an address, a write strobe, write data and read data. Each timer has the following controls:

- a start value (load register);
- a readable live count;
- a control word that turns the timer on, chooses between reloading and stopping at the end of the count, and picks a clock divider of 1, 16 or 256;
- a write-only register that acknowledges the timer's interrupt.

The count steps down by one on every divided clock tick. The tick in which a count of zero would step down is the expiry. On expiry, a periodic timer reloads its start value and keeps running. A one-shot timer parks at zero and stays there until software writes a new start value. Expiry sets a sticky interrupt flag. The flags of both timers are ORed onto a single interrupt line.

A typical use puts one timer in periodic mode as a system tick. The other runs free from the largest start value as a time base, and software reads it by inverting the count.

Top module: `dual_down_timer`

## Requirements
- R1: Byte offset 0x0 of a timer is its load register and holds a 24-bit value. Write-data bits above bit 23 are dropped and read back as zero. A write also copies the value into the count at once and restarts the divider phase. It takes precedence over a tick in the same cycle.
- R2: Offset 0x8 is the control word, with enable at bit 7, periodic at bit 6 and divider select at bits 3:2. It reads back with every other bit zero. While enable is 0, the count holds its value.
- R3: Offset 0x4 reads the live count. The count falls by exactly one on each tick, and writes to this offset change nothing.
- R4: A divider select of 0 gives a tick every clock. A select of 1 gives a tick every 16 clocks, and selects 2 and 3 give a tick every 256 clocks. The phase is counted from the load write or from the enable.
- R5: In periodic mode (bit 6 = 1), the tick at a count of zero reloads the load value and sets the interrupt flag.
- R6: In one-shot mode (bit 6 = 0), the tick at a count of zero sets the interrupt flag. The count then stays at zero and no further expiry occurs until the load register is written.
- R7: The interrupt flag stays set until any value is written to offset 0xC. An expiry in the same cycle as that write leaves the flag set. Reads of offset 0xC return zero.
- R8: `irq_out` is high exactly when at least one timer's flag is set.
- R9: The second timer's registers start at byte offset 0x20 (address bit 5 = 1). The two timers run independently.
- R10: Offsets 0x10 to 0x1C and 0x30 to 0x3C (address bit 4 = 1) read as zero, and writes to them change nothing.
- R11: After reset, every register, count and flag is zero and `irq_out` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, which also feeds the dividers |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address; bits 1:0 are ignored |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | OR of both timers' interrupt flags |

## Verification
The assertions assume that every write is a single-cycle strobe that takes effect at the next edge. They also assume that the only events that may change a count are a load write and a divided tick, so a count never jumps other than by one step, a reload or a parked zero. The stimulus drives the address, strobe and data just after each rising edge and holds them until the next one, so no write lands halfway through a cycle. The randomized phase keeps most start values small and often chooses the undivided clock. This makes expiries, reloads and acknowledge writes collide in the same cycle often, while the behavioural model stays within the legal register map and still exercises the unmapped offsets.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    localparam int DEF_CNT_W  = 24;
    localparam int DEF_DATA_W = 32;
    localparam int DEF_PS_W   = 8;

    // Control word bit positions (software-visible)
    localparam int BIT_EN    = 7;
    localparam int BIT_PER   = 6;
    localparam int BIT_PS_LO = 2;

    typedef enum logic [1:0] {
        REG_LOAD  = 2'd0,
        REG_COUNT = 2'd1,
        REG_CTRL  = 2'd2,
        REG_CLEAR = 2'd3
    } reg_e;

    typedef struct packed {
        logic       en;
        logic       per;
        logic [1:0] psel;
    } ctl_t;

    // Terminal value of the divider phase counter for a given select
    function automatic logic [DEF_PS_W-1:0] ps_limit(input logic [1:0] sel);
        case (sel)
            2'd0:    ps_limit = DEF_PS_W'(0);
            2'd1:    ps_limit = DEF_PS_W'(15);
            default: ps_limit = DEF_PS_W'(255);
        endcase
    endfunction

    function automatic ctl_t ctl_decode(input logic [7:0] w);
        ctl_t c;
        c.en   = w[BIT_EN];
        c.per  = w[BIT_PER];
        c.psel = w[BIT_PS_LO+1:BIT_PS_LO];
        return c;
    endfunction

    function automatic logic [7:0] ctl_encode(input ctl_t c);
        logic [7:0] w;
        w = '0;
        w[BIT_EN]                   = c.en;
        w[BIT_PER]                  = c.per;
        w[BIT_PS_LO+1:BIT_PS_LO]    = c.psel;
        return w;
    endfunction

endpackage

// File: rtl/dtmr_prescaler.sv
module dtmr_prescaler #(
    parameter int PS_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            restart,
    input  logic [PS_W-1:0] lim,
    output logic            tick
);
    logic [PS_W-1:0] phase_q;

    // >= keeps the phase from running past a limit lowered on the fly
    assign tick = run && (phase_q >= lim);

    always_ff @(posedge clk) begin
        if (rst || restart || !run || tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel
    import dtmr_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W,
    parameter int PS_W  = DEF_PS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_wr,
    input  logic             ctl_wr,
    input  logic             clr_wr,
    input  logic [CNT_W-1:0] ld_val,
    input  ctl_t             ctl_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] ld_q,
    output ctl_t             ctl_q,
    output logic             irq_q
);
    logic done_q;
    logic ps_tick;
    logic step;
    logic expire;

    dtmr_prescaler #(.PS_W(PS_W)) u_ps (
        .clk     (clk),
        .rst     (rst),
        .run     (ctl_q.en && !done_q),
        .restart (ld_wr),
        .lim     (PS_W'(ps_limit(ctl_q.psel))),
        .tick    (ps_tick)
    );

    assign step   = ps_tick && !ld_wr;
    assign expire = step && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            ld_q   <= '0;
            ctl_q  <= '0;
            done_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (ctl_wr) begin
                ctl_q <= ctl_val;
            end
            if (ld_wr) begin
                ld_q   <= ld_val;
                cnt_q  <= ld_val;
                done_q <= 1'b0;
            end else if (step) begin
                if (cnt_q != '0) begin
                    cnt_q <= cnt_q - 1'b1;
                end else if (ctl_q.per) begin
                    cnt_q <= ld_q;
                end else begin
                    done_q <= 1'b1;
                end
            end
            if (expire) begin
                irq_q <= 1'b1;
            end else if (clr_wr) begin
                irq_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer
    import dtmr_pkg::*;
#(
    parameter int NUM_TMR    = 2,
    parameter int CNT_W      = DEF_CNT_W,
    parameter int DATA_W     = DEF_DATA_W,
    parameter int PS_W       = DEF_PS_W,
    parameter int STRIDE_LSB = 5,
    localparam int SEL_W     = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1,
    localparam int ADDR_W    = STRIDE_LSB + SEL_W,
    localparam int OFF_W     = STRIDE_LSB - 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    logic [SEL_W-1:0] sel;
    logic [OFF_W-1:0] off;
    logic             mapped;
    reg_e             rsel;
    ctl_t             ctl_val;

    logic [NUM_TMR-1:0]            ch_ld_wr;
    logic [NUM_TMR-1:0]            ch_ctl_wr;
    logic [NUM_TMR-1:0]            ch_clr_wr;
    logic [NUM_TMR-1:0][CNT_W-1:0] ch_cnt;
    logic [NUM_TMR-1:0][CNT_W-1:0] ch_ld;
    logic [NUM_TMR-1:0]            ch_irq;
    logic [NUM_TMR-1:0]            ch_en;
    logic [NUM_TMR-1:0]            ch_per;
    ctl_t                          ch_ctl [NUM_TMR];

    logic wdata_unused;

    assign sel     = bus_addr[ADDR_W-1:STRIDE_LSB];
    assign off     = bus_addr[STRIDE_LSB-1:2];
    assign mapped  = (off[OFF_W-1:2] == '0);
    assign rsel    = reg_e'(off[1:0]);
    assign ctl_val = ctl_decode(bus_wdata[7:0]);
    assign wdata_unused = ^{bus_wdata[DATA_W-1:CNT_W], bus_addr[1:0]};

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_ch
        logic hit;
        assign hit          = bus_we && mapped && (sel == SEL_W'(i));
        assign ch_ld_wr[i]  = hit && (rsel == REG_LOAD);
        assign ch_ctl_wr[i] = hit && (rsel == REG_CTRL);
        assign ch_clr_wr[i] = hit && (rsel == REG_CLEAR);
        assign ch_en[i]     = ch_ctl[i].en;
        assign ch_per[i]    = ch_ctl[i].per;

        dtmr_channel #(.CNT_W(CNT_W), .PS_W(PS_W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .ld_wr   (ch_ld_wr[i]),
            .ctl_wr  (ch_ctl_wr[i]),
            .clr_wr  (ch_clr_wr[i]),
            .ld_val  (bus_wdata[CNT_W-1:0]),
            .ctl_val (ctl_val),
            .cnt_q   (ch_cnt[i]),
            .ld_q    (ch_ld[i]),
            .ctl_q   (ch_ctl[i]),
            .irq_q   (ch_irq[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_TMR; i++) begin
            if (mapped && (sel == SEL_W'(i))) begin
                case (rsel)
                    REG_LOAD:  bus_rdata = DATA_W'(ch_ld[i]);
                    REG_COUNT: bus_rdata = DATA_W'(ch_cnt[i]);
                    REG_CTRL:  bus_rdata = DATA_W'(ctl_encode(ch_ctl[i]));
                    default:   bus_rdata = '0;
                endcase
            end
        end
    end

    assign irq_out = |ch_irq;
endmodule

// File: rtl/dtmr_checker.sv
module dtmr_checker #(
    parameter int NUM_TMR = 2,
    parameter int CNT_W   = 24
) (
    input logic                            clk,
    input logic                            rst,
    input logic [NUM_TMR-1:0]              ld_wr,
    input logic [NUM_TMR-1:0]              clr_wr,
    input logic [NUM_TMR-1:0]              en,
    input logic [NUM_TMR-1:0]              per,
    input logic [NUM_TMR-1:0][CNT_W-1:0]   cnt,
    input logic [NUM_TMR-1:0]              irq,
    input logic [CNT_W-1:0]                ld_val
);
    for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
        // R1: a load write lands in the count on the next edge
        a_r1_load_copies: assert property (@(posedge clk) disable iff (rst)
            ld_wr[i] |=> (cnt[i] == $past(ld_val)));

        // R2: a disabled timer keeps its count
        a_r2_hold_when_off: assert property (@(posedge clk) disable iff (rst)
            (!ld_wr[i] && !en[i]) |=> $stable(cnt[i]));

        // R3: a nonzero count only holds or steps down by one
        a_r3_step_down: assert property (@(posedge clk) disable iff (rst)
            (!ld_wr[i] && cnt[i] != '0) |=>
                ((cnt[i] == $past(cnt[i])) || (cnt[i] == $past(cnt[i]) - 1'b1)));

        // R6: one-shot count parks at zero
        a_r6_oneshot_parks: assert property (@(posedge clk) disable iff (rst)
            (!ld_wr[i] && !per[i] && cnt[i] == '0) |=> (cnt[i] == '0));

        // R7: flag is sticky without an acknowledge write
        a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
            (irq[i] && !clr_wr[i]) |=> irq[i]);

        // R5: a flag only rises from an expiry at zero
        a_r5_rise_from_zero: assert property (@(posedge clk) disable iff (rst)
            $rose(irq[i]) |-> ($past(cnt[i]) == '0));
    end
endmodule

bind dual_down_timer dtmr_checker #(.NUM_TMR(NUM_TMR), .CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .ld_wr  (ch_ld_wr),
    .clr_wr (ch_clr_wr),
    .en     (ch_en),
    .per    (ch_per),
    .cnt    (ch_cnt),
    .irq    (ch_irq),
    .ld_val (bus_wdata[CNT_W-1:0])
);

// File: tb/test_dual_down_timer.sv
`timescale 1ns/1ps
module test_dual_down_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit chk_on = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dual_down_timer i_dual_down_timer (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    // ---------------- behavioural reference model ----------------
    int m_ld [2];
    int m_cnt[2];
    int m_pc [2];
    int m_ps [2];
    bit m_en [2];
    bit m_per[2];
    bit m_done[2];
    bit m_irq[2];

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 2; c++) begin
                m_ld[c] = 0; m_cnt[c] = 0; m_pc[c] = 0; m_ps[c] = 0;
                m_en[c] = 0; m_per[c] = 0; m_done[c] = 0; m_irq[c] = 0;
            end
        end else begin
            for (int c = 0; c < 2; c++) begin
                bit hit, ldw, ctw, clw, run, tick, expd;
                int lim;
                hit  = bus_we && (bus_addr[5] == c[0]) && !bus_addr[4];
                ldw  = hit && (bus_addr[3:2] == 2'd0);
                ctw  = hit && (bus_addr[3:2] == 2'd2);
                clw  = hit && (bus_addr[3:2] == 2'd3);
                lim  = (m_ps[c] == 0) ? 0 : (m_ps[c] == 1) ? 15 : 255;
                run  = m_en[c] && !m_done[c];
                tick = run && (m_pc[c] >= lim) && !ldw;
                expd = tick && (m_cnt[c] == 0);
                if (!run || ldw || (run && m_pc[c] >= lim)) m_pc[c] = 0;
                else m_pc[c] = m_pc[c] + 1;
                if (ldw) begin
                    m_ld[c]   = int'(bus_wdata & 32'h00FF_FFFF);
                    m_cnt[c]  = m_ld[c];
                    m_done[c] = 0;
                end else if (tick) begin
                    if (m_cnt[c] != 0) m_cnt[c] = m_cnt[c] - 1;
                    else if (m_per[c]) m_cnt[c] = m_ld[c];
                    else m_done[c] = 1;
                end
                if (expd) m_irq[c] = 1;
                else if (clw) m_irq[c] = 0;
                if (ctw) begin
                    m_en[c]  = bus_wdata[7];
                    m_per[c] = bus_wdata[6];
                    m_ps[c]  = int'(bus_wdata[3:2]);
                end
            end
        end
    end

    function automatic int model_read(input logic [5:0] a);
        int c;
        c = int'(a[5]);
        if (a[4]) return 0;
        case (a[3:2])
            2'd0: return m_ld[c];
            2'd1: return m_cnt[c];
            2'd2: return (int'(m_en[c]) << 7) | (int'(m_per[c]) << 6) | (m_ps[c] << 2);
            default: return 0;
        endcase
    endfunction

    function automatic string read_tag(input logic [5:0] a);
        if (a[4]) return "R10";
        case (a[3:2])
            2'd0: return "R1";
            2'd1: return "R3";
            2'd2: return "R2";
            default: return "R7";
        endcase
    endfunction

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (chk_on) begin
            int exp_rd;
            bit exp_irq;
            exp_rd  = model_read(bus_addr);
            exp_irq = m_irq[0] || m_irq[1];
            checks++;
            if (bus_rdata !== 32'(exp_rd)) begin
                errors++;
                $display("FAIL %s model read addr %h: actual %h expected %h",
                         read_tag(bus_addr), bus_addr, bus_rdata, exp_rd);
            end
            checks++;
            if (irq_out !== exp_irq) begin
                errors++;
                $display("FAIL R8 model irq_out: actual %b expected %b", irq_out, exp_irq);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        @(negedge clk);
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s read addr %h: actual %h expected %h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        @(negedge clk);
        checks++;
        if (irq_out !== exp) begin
            errors++;
            $display("FAIL %s irq_out: actual %b expected %b", tag, irq_out, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] held;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        chk_on = 1;

        // R11: reset state
        rd(6'h00, 32'h0, "R11");
        rd(6'h04, 32'h0, "R11");
        rd(6'h08, 32'h0, "R11");
        rd(6'h24, 32'h0, "R11");
        chk_irq(1'b0, "R11");

        // R1 / R3 / R2: periodic, undivided
        wr(6'h00, 32'd10);
        wr(6'h08, 32'hC0);
        rd(6'h04, 32'd10, "R1");
        rd(6'h04, 32'd9,  "R3");
        rd(6'h04, 32'd8,  "R3");
        rd(6'h08, 32'hC0, "R2");
        idle(20);
        chk_irq(1'b1, "R5");
        wr(6'h08, 32'h0);
        wr(6'h0C, 32'h5A);
        chk_irq(1'b0, "R7");
        rd(6'h0C, 32'h0, "R7");

        // R2: disabled count holds; R3: count offset is read-only
        bus_addr = 6'h04;
        @(negedge clk);
        held = bus_rdata;
        idle(5);
        rd(6'h04, held, "R2");
        wr(6'h04, 32'h123);
        rd(6'h04, held, "R3");
        wr(6'h00, 32'h01FF_FFFF);
        rd(6'h00, 32'h00FF_FFFF, "R1");

        // R6 / R9 / R4: second timer, one-shot, divide by 16
        wr(6'h20, 32'd3);
        wr(6'h28, 32'h84);
        idle(80);
        rd(6'h24, 32'd0, "R6");
        chk_irq(1'b1, "R6");
        idle(300);
        rd(6'h24, 32'd0, "R6");
        wr(6'h2C, 32'h0);
        idle(100);
        chk_irq(1'b0, "R6");
        rd(6'h04, 32'h00FF_FFFF, "R9");

        // R4: exact divide-by-16 timing
        wr(6'h20, 32'd1);
        idle(15);
        rd(6'h24, 32'd1, "R4");
        rd(6'h24, 32'd0, "R4");
        idle(15);
        chk_irq(1'b0, "R4");
        chk_irq(1'b1, "R4");
        wr(6'h2C, 32'h0);

        // R4: select 3 behaves as divide by 256
        wr(6'h28, 32'h8C);
        wr(6'h20, 32'd1);
        idle(255);
        rd(6'h24, 32'd1, "R4");
        rd(6'h24, 32'd0, "R4");
        wr(6'h28, 32'h0);
        wr(6'h2C, 32'h0);

        // R10: unmapped offsets
        wr(6'h10, 32'hFFFF_FFFF);
        wr(6'h30, 32'hFFFF_FFFF);
        rd(6'h10, 32'h0, "R10");
        rd(6'h30, 32'h0, "R10");
        rd(6'h00, 32'h00FF_FFFF, "R10");

        // R7: expiry beats acknowledge in the same cycle
        wr(6'h00, 32'd0);
        wr(6'h08, 32'hC0);
        wr(6'h0C, 32'h0);
        chk_irq(1'b1, "R7");
        wr(6'h08, 32'h0);
        wr(6'h0C, 32'h0);
        chk_irq(1'b0, "R7");

        // randomized phase, compared against the model every clock
        for (int n = 0; n < 20000; n++) begin
            logic [5:0] a;
            logic [31:0] d;
            a = {$urandom_range(1, 0) == 1, 1'b0, 2'(0), 2'b00};
            a[4:2] = 3'($urandom_range(7, 0));
            if ($urandom_range(15, 0) == 0) a[4] = 1'b1;
            else a[4] = 1'b0;
            if (a[3:2] == 2'd0)
                d = ($urandom_range(15, 0) == 0) ? 32'($urandom) : 32'($urandom_range(40, 0));
            else if (a[3:2] == 2'd2)
                d = {24'($urandom), ($urandom_range(3, 0) != 0), 1'($urandom), 2'b00,
                     ($urandom_range(3, 0) == 0) ? 2'($urandom) : 2'd0, 2'b00};
            else
                d = 32'($urandom);
            bus_addr  = a;
            bus_wdata = d;
            bus_we    = ($urandom_range(3, 0) == 0);
            @(posedge clk); #1;
        end
        bus_we = 1'b0;
        idle(2);
        finish_run();
    end

endmodule